// File: doc/BRIEF.md
# Crossbar Switching Core with Synchronised Broadcast

This block is the switching core of an N-by-N nonblocking crossbar with 16-bit ports. Every output port owns a multiplexer that selects one of the N inputs. A local arbiter drives that multiplexer. An input opens a packet by raising its frame signal and presenting either a binary destination index or a broadcast flag. The input holds both for as long as the frame stays high. The arbiter of the addressed output grants one input at a time and keeps that grant until the owner's frame drops. Words pass through the selected multiplexer in the same cycle, so packets cut through without being stored. Each source reaches each destination over a single path, which keeps the packets from any one sender in order.

Each arbiter uses fixed priority over a sampled window of requests. When its window is empty, an idle arbiter captures every live request addressed to it. It then serves the captured requests lowest index first. Any request that arrives while the window still holds members waits until the window has drained.

A broadcast request stops every arbiter from starting new point-to-point packets. Packets already under way run to completion. Once every output is idle, a single broadcast coordinator picks one broadcasting input and all outputs select it for its whole packet. When several broadcasts are pending, they are sampled and served one after another in the same way. Point-to-point service resumes only after the last of them. As a result, every destination sees the same broadcast order.

Top module: `xbar_switch_core`

## Requirements
- R1: During and directly after reset, no output frame, output data, output source index or input grant is asserted; all read zero.
- R2: While output o is assigned to input i and in_frame[i] is high, out_frame[o] is high, out_data slice o equals in_data slice i and out_src slice o holds i in binary, all in the same cycle. When out_frame[o] is low, the data and source slices of o read zero. Slice k of in_dest holds the binary index of the output that input k addresses.
- R3: A free output starts serving a requesting input at the first clock edge that sees the request, keeps the same input while that input's frame stays high, and releases it at the first edge that sees the frame low.
- R4: Within one sampled window, requests to an output are served lowest input index first.
- R5: A request that reaches an output after that output captured a non-empty window is served only after every member of that window.
- R6: While a point-to-point request waits at an output, at most 2*(N-1) other point-to-point packets start there.
- R7: While any broadcast request is live or a broadcast is in progress, no output starts a point-to-point packet. A packet already in progress is carried until its frame drops.
- R8: A broadcast starts only at an edge where every output was idle. From that edge on, all N outputs carry the broadcasting input and assert its grant until its frame drops.
- R9: Pending broadcasts are sampled and served one at a time, lowest input index first within a sample. Point-to-point packets blocked by them start only after the last one.
- R10: At every output, the packets from any one sender appear in the order that sender issued them, and all outputs show the same sequence of broadcast packets.
- R11: in_grant[i] is high exactly when some output is assigned to input i. No input is assigned to more than one output for point-to-point service.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_frame | input | N_PORTS | Per-input frame; high from the first word of a packet until it ends |
| in_bcast | input | N_PORTS | Per-input broadcast flag, held with the frame |
| in_dest | input | N_PORTS*IDX_W | Per-input binary destination index, held with the frame |
| in_data | input | N_PORTS*DATA_W | Per-input data word |
| in_grant | output | N_PORTS | Per-input grant; the presented word moves this cycle |
| out_frame | output | N_PORTS | Per-output frame |
| out_data | output | N_PORTS*DATA_W | Per-output data word |
| out_src | output | N_PORTS*IDX_W | Per-output binary index of the input being carried |

## Verification
The bench first aims at the sampling window: an input that arrives one cycle after two others to the same output. A plain fixed-priority arbiter would let the late low-index input jump ahead of an earlier request. The bench also raises a broadcast while a long point-to-point packet is running, with a second point-to-point request queued behind the broadcast. Here a design that failed to block new grants would slip the queued packet in ahead of the broadcast, and one that did not wait for idle would cut the running packet short. Two broadcasts raised together must come out lowest index first, identically at all outputs, and ahead of a simultaneous point-to-point request. Random mixed traffic then exposes any divergence in broadcast order between outputs, any reordering of a sender's packets, and any request that is overtaken too often.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  // Arbiter occupancy of one output port.
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_SEND = 1'b1
  } arb_state_e;

endpackage

// File: rtl/xbar_age_pick.sv
// Age-ordered pick: members of the sampled window first, otherwise a fresh
// capture of the live requests; lowest index wins inside that set.
module xbar_age_pick #(
  parameter  int unsigned N_PORTS = 8,
  localparam int unsigned IDX_W   = $clog2(N_PORTS)
) (
  input  logic [N_PORTS-1:0] window_q,
  input  logic [N_PORTS-1:0] live_req,
  output logic [N_PORTS-1:0] cand,
  output logic [N_PORTS-1:0] pick,
  output logic [IDX_W-1:0]   pick_idx
);

  localparam logic [N_PORTS-1:0] ONE_N = N_PORTS'(1);

  function automatic logic [N_PORTS-1:0] lowest_of(input logic [N_PORTS-1:0] v);
    return v & (~v + ONE_N);
  endfunction

  function automatic logic [IDX_W-1:0] index_of(input logic [N_PORTS-1:0] oh);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int k = 0; k < N_PORTS; k++) begin
      if (oh[k]) r = IDX_W'(k);
    end
    return r;
  endfunction

  logic [N_PORTS-1:0] window_live;

  always_comb begin
    window_live = window_q & live_req;
    cand        = (window_live != '0) ? window_live : live_req;
    pick        = lowest_of(cand);
    pick_idx    = index_of(pick);
  end

endmodule

// File: rtl/xbar_out_arbiter.sv
module xbar_out_arbiter
  import xbar_pkg::*;
#(
  parameter  int unsigned N_PORTS = 8,
  localparam int unsigned IDX_W   = $clog2(N_PORTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] req_vec,
  input  logic [N_PORTS-1:0] frame_vec,
  input  logic               hold_off,
  output logic               busy,
  output logic [IDX_W-1:0]   owner
);

  localparam logic [N_PORTS-1:0] ONE_N = N_PORTS'(1);

  arb_state_e         state_q;
  logic [N_PORTS-1:0] window_q;
  logic [N_PORTS-1:0] cand;
  logic [N_PORTS-1:0] pick;
  logic [IDX_W-1:0]   pick_idx;
  logic               start_grant;
  logic               end_packet;

  xbar_age_pick #(.N_PORTS(N_PORTS)) u_pick (
    .window_q (window_q),
    .live_req (req_vec),
    .cand     (cand),
    .pick     (pick),
    .pick_idx (pick_idx)
  );

  assign start_grant = (state_q == ARB_IDLE) && !hold_off && (cand != '0);
  assign end_packet  = (state_q == ARB_SEND) && !frame_vec[owner];
  assign busy        = (state_q == ARB_SEND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ARB_IDLE;
      owner    <= '0;
      window_q <= '0;
    end else if (start_grant) begin
      state_q  <= ARB_SEND;
      owner    <= pick_idx;
      window_q <= cand & ~pick;
    end else if (end_packet) begin
      state_q  <= ARB_IDLE;
    end
  end

  // R3: owner is kept while its frame is up
  a_r3_hold_until_frame_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && frame_vec[owner]) |=> (busy && $stable(owner)));

  // R7: no new point-to-point packet while a broadcast is pending or running
  a_r7_no_start_under_bcast: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && hold_off) |=> !busy);

  // R4: nobody with a lower index was in the candidate set
  a_r4_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !hold_off && cand != '0) |=>
      (($past(cand) & ((ONE_N << owner) - ONE_N)) == '0));

  // R5: a live window member is always served before fresh arrivals
  a_r5_window_before_new: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !hold_off && ((window_q & req_vec) != '0)) |=>
      (($past(window_q) & (ONE_N << owner)) != '0));

endmodule

// File: rtl/xbar_bcast_sync.sv
// Single coordinator for broadcasts: waits until all outputs are idle, then
// claims every output for one broadcasting input.
module xbar_bcast_sync #(
  parameter  int unsigned N_PORTS = 8,
  localparam int unsigned IDX_W   = $clog2(N_PORTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] bc_req,
  input  logic [N_PORTS-1:0] frame_vec,
  input  logic               all_idle,
  output logic               active,
  output logic [IDX_W-1:0]   owner
);

  localparam logic [N_PORTS-1:0] ONE_N = N_PORTS'(1);

  logic [N_PORTS-1:0] bwin_q;
  logic [N_PORTS-1:0] cand;
  logic [N_PORTS-1:0] pick;
  logic [IDX_W-1:0]   pick_idx;
  logic               bc_start;
  logic               bc_done;

  xbar_age_pick #(.N_PORTS(N_PORTS)) u_pick (
    .window_q (bwin_q),
    .live_req (bc_req),
    .cand     (cand),
    .pick     (pick),
    .pick_idx (pick_idx)
  );

  assign bc_start = !active && all_idle && (cand != '0);
  assign bc_done  = active && !frame_vec[owner];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      owner  <= '0;
      bwin_q <= '0;
    end else if (bc_start) begin
      active <= 1'b1;
      owner  <= pick_idx;
      bwin_q <= cand & ~pick;
    end else if (bc_done) begin
      active <= 1'b0;
    end
  end

  // R8: a broadcast only takes over outputs that were all idle
  a_r8_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(all_idle));

  // R9: one broadcast at a time, held to the end of its frame
  a_r9_single_bcast_held: assert property (@(posedge clk) disable iff (!rst_n)
    (active && frame_vec[owner]) |=> (active && $stable(owner)));

  // R9: lowest pending broadcaster in the sample goes first
  a_r9_lowest_bcast_first: assert property (@(posedge clk) disable iff (!rst_n)
    bc_start |=> (($past(cand) & ((ONE_N << owner) - ONE_N)) == '0));

endmodule

// File: rtl/xbar_out_mux.sv
module xbar_out_mux #(
  parameter  int unsigned N_PORTS = 8,
  parameter  int unsigned DATA_W  = 16,
  localparam int unsigned IDX_W   = $clog2(N_PORTS)
) (
  input  logic [IDX_W-1:0]          sel,
  input  logic                      sel_valid,
  input  logic [N_PORTS-1:0]        frame_vec,
  input  logic [N_PORTS*DATA_W-1:0] data_flat,
  output logic                      o_frame,
  output logic [DATA_W-1:0]         o_data,
  output logic [IDX_W-1:0]          o_src
);

  always_comb begin
    o_frame = sel_valid && frame_vec[sel];
    o_data  = o_frame ? data_flat[int'(sel)*DATA_W +: DATA_W] : '0;
    o_src   = o_frame ? sel : '0;
  end

endmodule

// File: rtl/xbar_switch_core.sv
module xbar_switch_core
  import xbar_pkg::*;
#(
  parameter  int unsigned N_PORTS = 8,
  parameter  int unsigned DATA_W  = 16,
  localparam int unsigned IDX_W   = $clog2(N_PORTS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_PORTS-1:0]        in_frame,
  input  logic [N_PORTS-1:0]        in_bcast,
  input  logic [N_PORTS*IDX_W-1:0]  in_dest,
  input  logic [N_PORTS*DATA_W-1:0] in_data,
  output logic [N_PORTS-1:0]        in_grant,
  output logic [N_PORTS-1:0]        out_frame,
  output logic [N_PORTS*DATA_W-1:0] out_data,
  output logic [N_PORTS*IDX_W-1:0]  out_src
);

  logic [N_PORTS-1:0] req_to  [N_PORTS];  // [output][input]
  logic [N_PORTS-1:0] hit_by  [N_PORTS];  // [input][output], point-to-point
  logic [N_PORTS-1:0] bc_req;
  logic [N_PORTS-1:0] arb_busy;
  logic [IDX_W-1:0]   arb_owner [N_PORTS];
  logic               bc_active;
  logic [IDX_W-1:0]   bc_owner;
  logic               bc_pending;
  logic               hold_off;
  logic               all_idle;

  // destination decode
  always_comb begin
    for (int o = 0; o < N_PORTS; o++) begin
      for (int i = 0; i < N_PORTS; i++) begin
        req_to[o][i] = in_frame[i] && !in_bcast[i] &&
                       (in_dest[i*IDX_W +: IDX_W] == IDX_W'(o));
      end
    end
    bc_req = in_frame & in_bcast;
  end

  assign bc_pending = (bc_req != '0);
  assign hold_off   = bc_pending || bc_active;
  assign all_idle   = (arb_busy == '0);

  xbar_bcast_sync #(.N_PORTS(N_PORTS)) u_bsync (
    .clk       (clk),
    .rst_n     (rst_n),
    .bc_req    (bc_req),
    .frame_vec (in_frame),
    .all_idle  (all_idle),
    .active    (bc_active),
    .owner     (bc_owner)
  );

  for (genvar o = 0; o < N_PORTS; o++) begin : g_out
    logic [IDX_W-1:0] sel;

    xbar_out_arbiter #(.N_PORTS(N_PORTS)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_vec   (req_to[o]),
      .frame_vec (in_frame),
      .hold_off  (hold_off),
      .busy      (arb_busy[o]),
      .owner     (arb_owner[o])
    );

    assign sel = bc_active ? bc_owner : arb_owner[o];

    xbar_out_mux #(.N_PORTS(N_PORTS), .DATA_W(DATA_W)) u_mux (
      .sel       (sel),
      .sel_valid (bc_active || arb_busy[o]),
      .frame_vec (in_frame),
      .data_flat (in_data),
      .o_frame   (out_frame[o]),
      .o_data    (out_data[o*DATA_W +: DATA_W]),
      .o_src     (out_src[o*IDX_W +: IDX_W])
    );
  end

  // grant return path
  always_comb begin
    for (int i = 0; i < N_PORTS; i++) begin
      for (int o = 0; o < N_PORTS; o++) begin
        hit_by[i][o] = arb_busy[o] && (arb_owner[o] == IDX_W'(i));
      end
      in_grant[i] = (bc_active && (bc_owner == IDX_W'(i))) || (hit_by[i] != '0);
    end
  end

  for (genvar i = 0; i < N_PORTS; i++) begin : g_chk
    // R11: one input never feeds two outputs point-to-point
    a_r11_single_path: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_by[i]));
  end

endmodule

// File: tb/xbar_switch_core_test.sv
module xbar_switch_core_test;

  localparam int N  = 8;
  localparam int DW = 16;
  localparam int IW = 3;
  localparam int WD_LIMIT = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [N-1:0]    in_frame = '0, in_bcast = '0;
  logic [N*IW-1:0] in_dest = '0;
  logic [N*DW-1:0] in_data = '0;
  logic [N-1:0]    in_grant, out_frame;
  logic [N*DW-1:0] out_data;
  logic [N*IW-1:0] out_src;

  xbar_switch_core #(.N_PORTS(N), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .in_frame(in_frame), .in_bcast(in_bcast),
    .in_dest(in_dest), .in_data(in_data), .in_grant(in_grant),
    .out_frame(out_frame), .out_data(out_data), .out_src(out_src)
  );

  typedef struct { int dest; bit bc; int len; int gap; } pkt_t;

  int n_checks = 0, n_fails = 0, cyc = 0;

  // traffic sources
  pkt_t pq [N][$];
  bit   s_act [N];
  bit   s_bc  [N];
  int   s_idx [N], s_len [N], s_seq [N], s_dest [N], s_wait [N];
  bit   is_bc [N][256];

  // reference model
  bit            m_busy [N];
  int            m_own  [N];
  logic [N-1:0]  m_win  [N];
  bit            m_bact;
  int            m_bown;
  logic [N-1:0]  m_bwin;

  // scoreboard
  int starts   [N][$];
  int bc_order [N][$];
  int last_seq [N][N];
  int waitc    [N][N];
  int bc_pushed = 0;

  function automatic int lowest(logic [N-1:0] v);
    for (int k = 0; k < N; k++) if (v[k]) return k;
    return -1;
  endfunction

  function automatic int dest_of(int i);
    return int'(in_dest[i*IW +: IW]);
  endfunction

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary_and_end();
    $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  task automatic model_reset();
    for (int o = 0; o < N; o++) begin
      m_busy[o] = 0; m_own[o] = 0; m_win[o] = '0;
    end
    m_bact = 0; m_bown = 0; m_bwin = '0;
  endtask

  // mirror of the clock edge that has just passed, using the held inputs
  task automatic model_step();
    bit           pend, was_bact, idle_all;
    logic [N-1:0] live, wl, cand;
    int           k;
    pend = 0;
    for (int i = 0; i < N; i++) if (in_frame[i] && in_bcast[i]) pend = 1;
    was_bact = m_bact;
    idle_all = 1;
    for (int o = 0; o < N; o++) if (m_busy[o]) idle_all = 0;
    for (int o = 0; o < N; o++) begin
      live = '0;
      for (int i = 0; i < N; i++)
        if (in_frame[i] && !in_bcast[i] && dest_of(i) == o) live[i] = 1'b1;
      if (!m_busy[o]) begin
        if (!(pend || was_bact)) begin
          wl   = m_win[o] & live;
          cand = (wl != '0) ? wl : live;
          k    = lowest(cand);
          if (k >= 0) begin
            m_busy[o] = 1; m_own[o] = k;
            cand[k] = 1'b0; m_win[o] = cand;
          end
        end
      end else if (!in_frame[m_own[o]]) begin
        m_busy[o] = 0;
      end
    end
    if (was_bact) begin
      if (!in_frame[m_bown]) m_bact = 0;
    end else if (idle_all && pend) begin
      live = in_frame & in_bcast;
      wl   = m_bwin & live;
      cand = (wl != '0) ? wl : live;
      k    = lowest(cand);
      m_bact = 1; m_bown = k;
      cand[k] = 1'b0; m_bwin = cand;
    end
  endtask

  task automatic compare();
    logic [N-1:0]    ef, eg;
    logic [N*DW-1:0] ed;
    logic [N*IW-1:0] es;
    int sel;
    ef = '0; eg = '0; ed = '0; es = '0;
    for (int o = 0; o < N; o++) begin
      sel = m_bact ? m_bown : (m_busy[o] ? m_own[o] : -1);
      if (sel >= 0 && in_frame[sel]) begin
        ef[o] = 1'b1;
        ed[o*DW +: DW] = in_data[sel*DW +: DW];
        es[o*IW +: IW] = IW'(sel);
      end
    end
    for (int i = 0; i < N; i++) begin
      if (m_bact && m_bown == i) eg[i] = 1'b1;
      for (int o = 0; o < N; o++) if (m_busy[o] && m_own[o] == i) eg[i] = 1'b1;
    end
    check(out_frame == ef, "R3", "out_frame", out_frame, ef);
    check(out_data == ed, "R2", "out_data", out_data, ed);
    check(out_src == es, "R4", "out_src", out_src, es);
    check(in_grant == eg, "R11", "in_grant", in_grant, eg);
  endtask

  task automatic observe();
    int src, seq, idx;
    for (int o = 0; o < N; o++) begin
      if (out_frame[o]) begin
        src = int'(out_data[o*DW+12 +: 4]);
        seq = int'(out_data[o*DW+4 +: 8]);
        idx = int'(out_data[o*DW +: 4]);
        if (idx == 0 && src < N) begin
          starts[o].push_back(src);
          // R10: per-sender order at this output
          check(seq > last_seq[o][src], "R10", "sender order", seq, last_seq[o][src] + 1);
          last_seq[o][src] = seq;
          if (is_bc[src][seq]) begin
            bc_order[o].push_back(src*256 + seq);
          end else begin
            for (int j = 0; j < N; j++) begin
              if (j != src && in_frame[j] && !in_bcast[j] && dest_of(j) == o) begin
                waitc[o][j]++;
                // R6: bounded overtaking
                check(waitc[o][j] <= 2*(N-1), "R6", "overtaken count", waitc[o][j], 2*(N-1));
              end
            end
            waitc[o][src] = 0;
          end
        end
      end
    end
  endtask

  task automatic sources_advance();
    pkt_t p;
    for (int i = 0; i < N; i++) begin
      if (s_act[i]) begin
        if (in_frame[i] && in_grant[i]) begin
          s_idx[i]++;
          if (s_idx[i] == s_len[i]) begin
            s_act[i] = 0;
            s_seq[i]++;
          end
        end
      end else if (pq[i].size() > 0) begin
        if (s_wait[i] < pq[i][0].gap) begin
          s_wait[i]++;
        end else begin
          p = pq[i].pop_front();
          s_wait[i] = 0;
          s_act[i] = 1; s_idx[i] = 0; s_len[i] = p.len;
          s_dest[i] = p.dest; s_bc[i] = p.bc;
          is_bc[i][s_seq[i]] = p.bc;
        end
      end
    end
  endtask

  task automatic drive_inputs();
    for (int i = 0; i < N; i++) begin
      in_frame[i] = s_act[i];
      in_bcast[i] = s_act[i] && s_bc[i];
      in_dest[i*IW +: IW] = s_act[i] ? IW'(s_dest[i]) : '0;
      in_data[i*DW +: DW] = s_act[i] ? {4'(i), 8'(s_seq[i]), 4'(s_idx[i])} : '0;
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (rst_n) model_step(); else model_reset();
    compare();
    observe();
    sources_advance();
    drive_inputs();
    if (cyc > WD_LIMIT) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, WD_LIMIT);
      summary_and_end();
    end
  endtask

  function automatic bit all_quiet();
    for (int i = 0; i < N; i++) if (s_act[i] || pq[i].size() > 0) return 0;
    for (int o = 0; o < N; o++) if (m_busy[o]) return 0;
    return !m_bact;
  endfunction

  task automatic drain();
    tick();
    while (!all_quiet()) tick();
    repeat (3) tick();
  endtask

  task automatic push(int i, int dest, bit bc, int len, int gap);
    pkt_t p;
    p.dest = dest; p.bc = bc; p.len = len; p.gap = gap;
    pq[i].push_back(p);
    if (bc) bc_pushed++;
  endtask

  task automatic clear_starts();
    for (int o = 0; o < N; o++) starts[o].delete();
  endtask

  function automatic bit has_src(int o, int s);
    foreach (starts[o][k]) if (starts[o][k] == s) return 1;
    return 0;
  endfunction

  initial begin
    for (int i = 0; i < N; i++) begin
      s_act[i] = 0; s_seq[i] = 0; s_wait[i] = 0; s_idx[i] = 0; s_len[i] = 0;
      for (int o = 0; o < N; o++) begin last_seq[o][i] = -1; waitc[o][i] = 0; end
    end
    model_reset();
    repeat (3) tick();
    // R1: quiet outputs under reset
    check(out_frame == '0, "R1", "out_frame in reset", out_frame, 0);
    check(in_grant == '0, "R1", "in_grant in reset", in_grant, 0);
    check(out_data == '0 && out_src == '0, "R1", "out_data/out_src in reset", out_data, 0);
    rst_n = 1'b1;
    tick();
    check(out_frame == '0 && in_grant == '0, "R1", "idle after reset", {out_frame, in_grant}, 0);

    // R4: three simultaneous requests to output 2
    clear_starts();
    push(3, 2, 0, 3, 0); push(1, 2, 0, 3, 0); push(5, 2, 0, 3, 0);
    drain();
    check(starts[2].size() == 3 && starts[2][0] == 1 && starts[2][1] == 3 && starts[2][2] == 5,
          "R4", "service order at out2", starts[2].size() > 0 ? starts[2][0] : -1, 1);

    // R5: late low-index arrival waits for the sampled window
    clear_starts();
    push(1, 4, 0, 4, 0); push(5, 4, 0, 4, 0); push(0, 4, 0, 4, 1);
    drain();
    check(starts[4].size() == 3 && starts[4][0] == 1 && starts[4][1] == 5 && starts[4][2] == 0,
          "R5", "service order at out4", starts[4].size() > 2 ? starts[4][2] : -1, 0);

    // R7/R8: broadcast behind a long packet, p2p queued behind broadcast
    clear_starts();
    push(2, 6, 0, 8, 0); push(7, 0, 1, 3, 2); push(4, 1, 0, 2, 3);
    drain();
    check(starts[6].size() == 2 && starts[6][0] == 2 && starts[6][1] == 7,
          "R7", "running packet finishes first at out6", starts[6].size() > 0 ? starts[6][0] : -1, 2);
    check(starts[1].size() == 2 && starts[1][0] == 7 && starts[1][1] == 4,
          "R7", "p2p held behind broadcast at out1", starts[1].size() > 0 ? starts[1][0] : -1, 7);
    begin
      int seen = 0;
      for (int o = 0; o < N; o++) if (has_src(o, 7)) seen++;
      check(seen == N, "R8", "outputs carrying broadcast", seen, N);
    end

    // R9: two broadcasts and a p2p request raised together
    clear_starts();
    push(6, 0, 1, 2, 0); push(3, 0, 1, 2, 0); push(5, 0, 0, 2, 0);
    drain();
    check(starts[0].size() == 3 && starts[0][0] == 3 && starts[0][1] == 6 && starts[0][2] == 5,
          "R9", "order at out0", starts[0].size() > 0 ? starts[0][0] : -1, 3);
    check(starts[7].size() == 2 && starts[7][0] == 3 && starts[7][1] == 6,
          "R9", "broadcast order at out7", starts[7].size() > 0 ? starts[7][0] : -1, 3);

    // random mixed traffic
    for (int i = 0; i < N; i++) begin
      for (int n = 0; n < 30; n++) begin
        push(i, int'($urandom_range(N-1)), ($urandom_range(9) == 0), int'($urandom_range(6, 1)),
             int'($urandom_range(3)));
      end
    end
    drain();

    // R10: identical broadcast sequence everywhere
    check(bc_order[0].size() == bc_pushed, "R10", "broadcasts seen at out0", bc_order[0].size(), bc_pushed);
    for (int o = 1; o < N; o++) begin
      bit same;
      same = (bc_order[o].size() == bc_order[0].size());
      if (same) foreach (bc_order[o][k]) if (bc_order[o][k] != bc_order[0][k]) same = 0;
      check(same, "R10", "broadcast order matches out0", o, 0);
    end

    summary_and_end();
  end

endmodule